// File: doc/BRIEF.md
# Reset Output Sequencer

This block gathers nine reset request lines and turns them into one active-low reset pulse whose length depends on which request won and on the clocking mode. While the pulse runs, an internal system-reset flag marks the pulse as a full system reset. A sampling strobe marks the last four cycles, when configuration inputs are to be captured. A one-hot cause register records which source produced the most recent pulse.

Requests are asynchronous. Each passes through a two-flop synchronizer and acts on its rising edge. The external pin request must be seen on two consecutive synchronized samples before it counts. The loss-of-lock line is a request and also a gate: while it stays asserted, the pulse is not released. The software external source pulses the output without raising the system-reset flag.

Top module: `rst_sequencer`

## Requirements
- R1: After `rst` the block is idle: `rst_out_n`=1, `sys_rst_o`=0, `cfg_sample_o`=0, `cause_o`=0. `rst_out_n` is 0 exactly while a reset sequence is in progress.
- R2: Request bits are indexed 0 power-on, 1 external pin, 2 loss of lock, 3 watchdog, 4 core, 5 software watchdog, 6 loss of clock, 7 software system, 8 software external. When several events arrive on the same cycle, the lowest index wins.
- R3: With `long_mode_i`=0, the output stays low for 2400+10*i cycles plus 4 sampling cycles for winning source i.
- R4: With `long_mode_i`=1, the output stays low for 16000+100*i cycles plus 4 sampling cycles.
- R5: `cfg_sample_o` is 1 only during the final 4 cycles of the sequence, after the main count.
- R6: `sys_rst_o` equals the inverse of `rst_out_n`, except when the current source is index 8. In that case `sys_rst_o` stays 0 while the output is low.
- R7: After the sampling cycles, the output is held low for as long as the synchronized request bit 2 is 1. It is released on the first cycle that bit is seen at 0.
- R8: A new request event during a sequence restarts the full count. The restart uses the lower index of the running source and the new one.
- R9: `cause_o` is the one-hot bit (bit i for source i) of the source that started or last restarted the sequence. It keeps that value after release until the next sequence starts.
- R10: Bits pass two synchronizer flops, so a sequence starts on the second clock edge after the first edge that samples the request. Bit 1 must be sampled high on two consecutive edges; a one-cycle pulse on bit 1 is ignored.
- R11: Requests act on their rising edge. A request held high does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| req_i | input | 9 | Reset request lines, index order as in R2 |
| long_mode_i | input | 1 | 1 selects the long count set, 0 the short set |
| rst_out_n | output | 1 | Active-low reset output |
| sys_rst_o | output | 1 | Internal system reset active |
| cfg_sample_o | output | 1 | Configuration sampling strobe |
| cause_o | output | 9 | One-hot cause of the latest sequence |

## Verification
The hardest case to reach is a sequence restarted partway through by a second request, whose priority must be merged with the running source. The stimulus starts a low-priority source, fires a higher-priority source a thousand cycles later, and then fires a lower-priority one. The expected total low time is worked out from the three edge times. The loss-of-lock hold is reached by keeping bit 2 high well past the sampling window. The pin filter is probed with one-cycle and two-cycle pulses.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    localparam int NUM_SRC     = 9;
    localparam int SRC_W       = $clog2(NUM_SRC);
    localparam int CNT_W       = 15;
    localparam int SHORT_BASE  = 2400;
    localparam int SHORT_STEP  = 10;
    localparam int LONG_BASE   = 16000;
    localparam int LONG_STEP   = 100;
    localparam int SRC_PIN     = 1;
    localparam int SRC_LOCK    = 2;
    localparam int SRC_SWEXT   = 8;

    typedef logic [SRC_W-1:0] src_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_SAMPLE,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
    } pick_t;

    function automatic logic [CNT_W-1:0] main_len(input src_idx_t idx, input logic long_mode);
        int v;
        if (long_mode) v = LONG_BASE + LONG_STEP * int'(idx);
        else           v = SHORT_BASE + SHORT_STEP * int'(idx);
        return CNT_W'(v);
    endfunction
endpackage

// File: rtl/rst_req_sync.sv
module rst_req_sync #(
    parameter int N       = 9,
    parameter int STAGES  = 2,
    parameter int PIN_IDX = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] evt
);
    logic [N-1:0] stg [STAGES];
    logic [N-1:0] s_d;
    logic [N-1:0] acc_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else if (g == 0) stg[g] <= req_raw;
                else stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_comb begin
        lvl          = stg[STAGES-1];
        lvl[PIN_IDX] = stg[STAGES-1][PIN_IDX] & s_d[PIN_IDX];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_d   <= '0;
            acc_d <= '0;
        end else begin
            s_d   <= stg[STAGES-1];
            acc_d <= lvl;
        end
    end

    assign evt = lvl & ~acc_d;

    generate
        if (STAGES == 2) begin : g_pin_chk
            AST_PIN_TWO_SAMPLES: assert property (@(posedge clk) disable iff (rst)
                evt[PIN_IDX] |-> ($past(req_raw[PIN_IDX], 2) && $past(req_raw[PIN_IDX], 3))); // R10
        end
    endgenerate
endmodule

// File: rtl/rst_prio_pick.sv
module rst_prio_pick
    import rst_seq_pkg::*;
#(
    parameter int N = 9
) (
    input  logic [N-1:0] evt,
    input  logic         cur_valid,
    input  src_idx_t     cur_idx,
    output pick_t        pick
);
    src_idx_t low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (evt[i]) low_idx = src_idx_t'(i);
        end
        pick.valid = |evt;
        pick.idx   = (cur_valid && (cur_idx < low_idx)) ? cur_idx : low_idx;
    end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int N          = 9,
    parameter int SAMPLE_CYC = 4,
    parameter int SWEXT_IDX  = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  pick_t        pick,
    input  logic         long_mode,
    input  logic         lock_lvl,
    output logic         rst_out_n,
    output logic         sys_rst,
    output logic         cfg_sample,
    output logic [N-1:0] cause,
    output logic         cur_valid,
    output src_idx_t     cur_idx
);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            cur_idx <= '0;
            cause   <= '0;
        end else if (pick.valid) begin
            state   <= ST_COUNT;
            cnt     <= main_len(pick.idx, long_mode) - 1'b1;
            cur_idx <= pick.idx;
            cause   <= N'(1) << pick.idx;
        end else begin
            case (state)
                ST_COUNT: begin
                    if (cnt == '0) begin
                        state <= ST_SAMPLE;
                        cnt   <= SAMPLE_LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (cnt == '0) state <= lock_lvl ? ST_HOLD : ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_HOLD: begin
                    if (!lock_lvl) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cur_valid  = (state != ST_IDLE);
    assign rst_out_n  = (state == ST_IDLE);
    assign cfg_sample = (state == ST_SAMPLE);
    assign sys_rst    = cur_valid && (cur_idx != src_idx_t'(SWEXT_IDX));

    AST_SAMPLE_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
        cfg_sample |-> !rst_out_n); // R5
    AST_SAMPLE_FOUR: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_sample) |-> $past(cfg_sample, SAMPLE_CYC)); // R5
    AST_SYS_INSIDE_OUT: assert property (@(posedge clk) disable iff (rst)
        sys_rst |-> !rst_out_n); // R6
    AST_RELEASE_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> !$past(lock_lvl)); // R7
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause)); // R9
    AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> $stable(cause)); // R9
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int N_SRC       = NUM_SRC,
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_i,
    input  logic             long_mode_i,
    output logic             rst_out_n,
    output logic             sys_rst_o,
    output logic             cfg_sample_o,
    output logic [N_SRC-1:0] cause_o
);
    logic [N_SRC-1:0] req_lvl;
    logic [N_SRC-1:0] req_evt;
    logic             cur_valid;
    src_idx_t         cur_idx;
    pick_t            pick;

    rst_req_sync #(
        .N       (N_SRC),
        .STAGES  (SYNC_STAGES),
        .PIN_IDX (SRC_PIN)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .req_raw (req_i),
        .lvl     (req_lvl),
        .evt     (req_evt)
    );

    rst_prio_pick #(
        .N (N_SRC)
    ) i_pick (
        .evt       (req_evt),
        .cur_valid (cur_valid),
        .cur_idx   (cur_idx),
        .pick      (pick)
    );

    rst_seq_fsm #(
        .N          (N_SRC),
        .SAMPLE_CYC (SAMPLE_CYC),
        .SWEXT_IDX  (SRC_SWEXT)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .pick       (pick),
        .long_mode  (long_mode_i),
        .lock_lvl   (req_lvl[SRC_LOCK]),
        .rst_out_n  (rst_out_n),
        .sys_rst    (sys_rst_o),
        .cfg_sample (cfg_sample_o),
        .cause      (cause_o),
        .cur_valid  (cur_valid),
        .cur_idx    (cur_idx)
    );
endmodule

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;
    logic       clk = 0;
    logic       rst = 1;
    logic [8:0] req = '0;
    logic       mode = 0;
    logic       rst_out_n, sys_rst_o, cfg_sample_o;
    logic [8:0] cause_o;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    rst_sequencer i_rst_sequencer (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .long_mode_i  (mode),
        .rst_out_n    (rst_out_n),
        .sys_rst_o    (sys_rst_o),
        .cfg_sample_o (cfg_sample_o),
        .cause_o      (cause_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int len_of(input int i, input bit lm);
        return lm ? (16000 + 100 * i) : (2400 + 10 * i);
    endfunction

    // Behavioural reference model
    logic [8:0] h1 = 0, h2 = 0, h3 = 0, h4 = 0;
    bit         m_act = 0;
    int         m_rem = 0;
    int         m_cur = 0;
    logic [8:0] m_cause = 0;

    always @(posedge clk) begin
        logic [8:0] a_now, a_prev, ev;
        int w;
        cycles++;
        if (rst) begin
            m_act = 0; m_rem = 0; m_cur = 0; m_cause = 0;
            h1 = 0; h2 = 0; h3 = 0; h4 = 0;
        end else begin
            a_now  = h2; a_now[1]  = h2[1] & h3[1];
            a_prev = h3; a_prev[1] = h3[1] & h4[1];
            ev = a_now & ~a_prev;
            if (ev != 0) begin
                w = 99;
                for (int i = 8; i >= 0; i--) if (ev[i]) w = i;
                if (m_act && m_cur < w) w = m_cur;
                m_cur = w;
                m_rem = len_of(w, mode) + 4;
                m_cause = 9'(1) << w;
                m_act = 1;
            end else if (m_act) begin
                if (m_rem > 1) m_rem--;
                else if (m_rem == 1) begin
                    if (h2[2]) m_rem = 0;
                    else m_act = 0;
                end else if (!h2[2]) m_act = 0;
            end
            h4 = h3; h3 = h2; h2 = h1; h1 = req;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(rst_out_n == !m_act, "R1 rst_out_n vs model", int'(rst_out_n), int'(!m_act));
            chk(sys_rst_o == (m_act && m_cur != 8), "R6 sys_rst_o vs model",
                int'(sys_rst_o), int'(m_act && m_cur != 8));
            chk(cfg_sample_o == (m_act && m_rem >= 1 && m_rem <= 4), "R5 cfg_sample_o vs model",
                int'(cfg_sample_o), int'(m_act && m_rem >= 1 && m_rem <= 4));
            chk(cause_o == m_cause, "R9 cause_o vs model", int'(cause_o), int'(m_cause));
        end
    end

    always @(posedge clk) begin
        if (cycles > 190000) begin
            n_errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic pulse(input logic [8:0] v, input int n);
        req = v;
        repeat (n) @(negedge clk);
        req = '0;
    endtask

    task automatic measure(output int low, output int smp, output int sysc);
        low = 0; smp = 0; sysc = 0;
        while (rst_out_n) @(negedge clk);
        while (!rst_out_n) begin
            low++;
            if (cfg_sample_o) smp++;
            if (sys_rst_o) sysc++;
            @(negedge clk);
        end
    endtask

    initial begin
        int low, smp, sysc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rst_out_n == 1 && sys_rst_o == 0 && cfg_sample_o == 0 && cause_o == 0,
            "R1 reset state", int'({rst_out_n, sys_rst_o, cfg_sample_o}), 4);
        rst = 0;
        repeat (5) @(negedge clk);

        // R3 / R5 / R6 / R9: every source, short mode
        for (int s = 0; s < 9; s++) begin
            fork
                pulse(9'(1) << s, 3);
                measure(low, smp, sysc);
            join
            chk(low == len_of(s, 0) + 4, "R3 short length", low, len_of(s, 0) + 4);
            chk(smp == 4, "R5 sample cycles", smp, 4);
            chk(sysc == ((s == 8) ? 0 : low), "R6 system reset cycles", sysc, (s == 8) ? 0 : low);
            chk(cause_o == (9'(1) << s), "R9 cause kept after release", int'(cause_o), 1 << s);
            repeat (10) @(negedge clk);
        end

        // R4: long mode
        mode = 1;
        repeat (5) @(negedge clk);
        fork pulse(9'(1) << 5, 3); measure(low, smp, sysc); join
        chk(low == 16504, "R4 long length src5", low, 16504);
        repeat (10) @(negedge clk);
        fork pulse(9'(1) << 8, 3); measure(low, smp, sysc); join
        chk(low == 16804, "R4 long length src8", low, 16804);
        chk(sysc == 0, "R6 software external no system reset", sysc, 0);
        mode = 0;
        repeat (10) @(negedge clk);

        // R2: simultaneous requests
        fork pulse(9'b1_0011_0000, 3); measure(low, smp, sysc); join
        chk(low == 2444, "R2 lowest index length", low, 2444);
        chk(cause_o == 9'b0_0001_0000, "R2 lowest index cause", int'(cause_o), 16);
        repeat (10) @(negedge clk);

        // R8: restart with priority merge
        fork
            begin
                pulse(9'(1) << 6, 3);
                repeat (1000) @(negedge clk);
                pulse(9'(1) << 3, 3);
                repeat (500) @(negedge clk);
                pulse(9'(1) << 7, 3);
            end
            measure(low, smp, sysc);
        join
        chk(low == 3940, "R8 restart total length", low, 3940);
        chk(cause_o == (9'(1) << 3), "R8 merged source cause", int'(cause_o), 8);
        repeat (10) @(negedge clk);

        // R7: loss of lock holds release
        fork pulse(9'(1) << 2, 5000); measure(low, smp, sysc); join
        chk(low == 5000, "R7 lock hold length", low, 5000);
        chk(smp == 4, "R7 sample window before hold", smp, 4);
        repeat (10) @(negedge clk);

        // R10: one-cycle pin pulse ignored, two-cycle pulse accepted
        pulse(9'(1) << 1, 1);
        repeat (10) begin
            chk(rst_out_n == 1, "R10 pin glitch ignored", int'(rst_out_n), 1);
            @(negedge clk);
        end
        fork pulse(9'(1) << 1, 2); measure(low, smp, sysc); join
        chk(low == 2414, "R10 two-sample pin accepted", low, 2414);
        repeat (10) @(negedge clk);

        // R11: held request does not retrigger
        req = 9'(1) << 3;
        measure(low, smp, sysc);
        chk(low == 2434, "R11 held request length", low, 2434);
        repeat (50) @(negedge clk);
        chk(rst_out_n == 1, "R11 no retrigger while held", int'(rst_out_n), 1);
        req = '0;
        repeat (10) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule